// File: doc/BRIEF.md
# Bitonic Sorter with Top-K Extraction

This block orders 32 tagged keys. Each key is 8 bits wide and travels with a 6-bit index tag. The tag is whatever the caller attaches, for example the slot number of a candidate box or score. The block works in one of two modes. In full mode it produces all 32 pairs in descending order. In Top-K mode it returns only the K largest pairs, also in descending order.

The engine is a bitonic compare-exchange network. It runs as one reusable layer of 32 lanes, and one layer is applied per clock. The first ten layers leave the lower half of the working array in descending order and the upper half in ascending order. Full mode then runs the five remaining merge layers. Top-K mode skips them. Instead it keeps one head pointer into each ordered half and moves the larger head into the result on each cycle. K may be any value from 1 to 16.

A job is offered with a valid/ready pair. The result is held on the outputs until the caller acknowledges it, and only then does the block accept the next job. A one-cycle `done` pulse marks the moment the result becomes available.

Top module: `topk_bitonic_sorter`

## Requirements
- R1: With `in_mode`=0, the result holds all 32 input pairs with keys in non-increasing order. Output slot 0 holds the largest key. Element i of a bus sits at `in_keys[8i+7:8i]` / `in_idxs[6i+5:6i]`, and the same layout is used on `out_keys` / `out_idxs`.
- R2: Pairs with equal keys come out with the lower index tag first.
- R3: Every output key appears next to the index tag it arrived with.
- R4: With `in_mode`=1, output slots 0..K-1 hold the K largest pairs, ordered as in R1 and R2. Slots K..31 read as key 0 and index 0.
- R5: A K of 0 on `in_k` is treated as 1. Any K above 16 is treated as 16.
- R6: `out_valid` rises 15 clock edges after the accepting edge in full mode, and 10+K edges after it in Top-K mode.
- R7: `in_ready` is high exactly when the block is idle. A job is taken on an edge where `in_valid` and `in_ready` are both high. Input values while the block is busy have no effect on the result.
- R8: `out_valid` stays high and both output buses stay unchanged until `out_ack` is sampled high. On the next cycle `in_ready` is high again.
- R9: `done` is high for exactly one cycle, the first cycle in which `out_valid` is high.
- R10: After reset, `in_ready` is 1 and both `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A job is offered |
| in_ready | output | 1 | Block is idle and will take a job |
| in_mode | input | 1 | 0 = full sort, 1 = Top-K |
| in_k | input | 5 | Number of pairs wanted in Top-K mode |
| in_keys | input | 256 | 32 keys, element i at bits 8i+7:8i |
| in_idxs | input | 192 | 32 index tags, element i at bits 6i+5:6i |
| out_valid | output | 1 | Result is available and held |
| out_ack | input | 1 | Caller has consumed the result |
| done | output | 1 | One-cycle pulse when the result appears |
| out_keys | output | 256 | Ordered keys |
| out_idxs | output | 192 | Index tags that belong to `out_keys` |

## Verification
A fault in the layer schedule or in a compare direction leaves the working array only partly ordered. This shows up at the ports in the very first result cycle, because a key pair or a key/tag pairing differs from the independently sorted reference.

A head pointer that advances wrongly in Top-K mode duplicates or drops a candidate in the result. A wrong phase count or a wrong stage limit moves `done` away from the cycle predicted by R6. The per-clock model of ready, valid and done flags this on the same cycle.

Stimulus covers the following patterns:
- random keys
- all-equal keys
- keys that arrive already sorted
- heavy duplicates
- K values at the edges and beyond them
- inputs that change while a job is in flight

// File: rtl/tks_pkg.sv
`timescale 1ns/1ps
package tks_pkg;

    localparam int N         = 32;
    localparam int KEY_W     = 8;
    localparam int IDX_W     = 6;
    localparam int K_MAX     = 16;
    localparam int K_W       = $clog2(N);
    localparam int LOG_N     = $clog2(N);
    localparam int HALF      = N / 2;
    localparam int MERGE_STG = LOG_N * (LOG_N - 1) / 2;
    localparam int FULL_STG  = LOG_N * (LOG_N + 1) / 2;
    localparam int STG_W     = $clog2(FULL_STG);
    localparam int LOG_W     = $clog2(LOG_N + 1);
    localparam int CNT_W     = $clog2(HALF + 1);
    localparam int LAT_W     = $clog2(MERGE_STG + K_MAX + 1);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [IDX_W-1:0] idx;
    } item_t;

    typedef struct packed {
        logic [LOG_W-1:0] blk_log;
        logic [LOG_W-1:0] dist_log;
    } stage_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MERGE,
        PH_PICK,
        PH_HOLD
    } phase_e;

    // Strict order: larger key wins, on equal keys the lower tag wins.
    function automatic logic ranks_above(input item_t a, input item_t b);
        return {a.key, ~a.idx} > {b.key, ~b.idx};
    endfunction

    // Maps a layer number to its block size and compare distance (log2).
    function automatic stage_t stage_plan(input logic [STG_W-1:0] s);
        stage_t r;
        int     c;
        r = '0;
        c = 0;
        for (int p = 1; p <= LOG_N; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (c == int'(s)) begin
                    r.blk_log  = LOG_W'(p);
                    r.dist_log = LOG_W'(q);
                end
                c++;
            end
        end
        return r;
    endfunction

    function automatic logic [K_W-1:0] clamp_k(input logic [K_W-1:0] k);
        if (k == '0)
            return K_W'(1);
        if (k > K_W'(K_MAX))
            return K_W'(K_MAX);
        return k;
    endfunction

endpackage

// File: rtl/tks_layer.sv
`timescale 1ns/1ps
// One compare-exchange layer of the bitonic network, all lanes in parallel.
module tks_layer
    import tks_pkg::*;
(
    input  item_t [N-1:0] d,
    input  stage_t        plan,
    output item_t [N-1:0] q
);

    always_comb begin
        logic [LOG_N-1:0] pos;
        logic [LOG_N-1:0] mate;
        logic [LOG_N-1:0] dist_bit;
        logic [LOG_N-1:0] blk_bit;
        logic             low_side;
        logic             desc_blk;
        logic             keep_big;
        item_t            a;
        item_t            b;
        q = d;
        for (int i = 0; i < N; i++) begin
            pos      = LOG_N'(i);
            dist_bit = LOG_N'(1) << plan.dist_log;
            blk_bit  = LOG_N'(1) << plan.blk_log;
            mate     = pos ^ dist_bit;
            low_side = (pos & dist_bit) == '0;
            desc_blk = (pos & blk_bit) == '0;
            keep_big = (desc_blk == low_side);
            a        = d[pos];
            b        = d[mate];
            q[i]     = (ranks_above(a, b) == keep_big) ? a : b;
        end
    end

endmodule

// File: rtl/tks_pick.sv
`timescale 1ns/1ps
// Chooses the larger head of the descending lower half and ascending upper half.
module tks_pick
    import tks_pkg::*;
(
    input  item_t [N-1:0]    w,
    input  logic [CNT_W-1:0] taken_a,
    input  logic [CNT_W-1:0] taken_b,
    output item_t            best,
    output logic             from_a
);

    item_t head_a;
    item_t head_b;
    logic  a_ok;
    logic  b_ok;

    always_comb begin
        a_ok   = taken_a < CNT_W'(HALF);
        b_ok   = taken_b < CNT_W'(HALF);
        head_a = w[LOG_N'(taken_a)];
        head_b = w[LOG_N'(N - 1) - LOG_N'(taken_b)];
        from_a = a_ok && (!b_ok || ranks_above(head_a, head_b));
        best   = from_a ? head_a : head_b;
    end

endmodule

// File: rtl/topk_bitonic_sorter.sv
`timescale 1ns/1ps
module topk_bitonic_sorter
    import tks_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_mode,
    input  logic [K_W-1:0]       in_k,
    input  logic [N*KEY_W-1:0]   in_keys,
    input  logic [N*IDX_W-1:0]   in_idxs,
    output logic                 out_valid,
    input  logic                 out_ack,
    output logic                 done,
    output logic [N*KEY_W-1:0]   out_keys,
    output logic [N*IDX_W-1:0]   out_idxs
);

    localparam logic [STG_W-1:0] LAST_FULL  = STG_W'(FULL_STG - 1);
    localparam logic [STG_W-1:0] LAST_MERGE = STG_W'(MERGE_STG - 1);

    item_t [N-1:0]    in_items;
    item_t [N-1:0]    work;
    item_t [N-1:0]    lay_q;
    item_t [N-1:0]    res;
    phase_e           phase;
    logic [STG_W-1:0] stg;
    logic             mode_q;
    logic [K_W-1:0]   k_q;
    logic [K_W-1:0]   n_out;
    logic [CNT_W-1:0] taken_a;
    logic [CNT_W-1:0] taken_b;
    logic             done_q;
    item_t            best;
    logic             from_a;
    stage_t           plan;

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            assign in_items[g] = {in_keys[g*KEY_W +: KEY_W], in_idxs[g*IDX_W +: IDX_W]};
            assign out_keys[g*KEY_W +: KEY_W] = res[g].key;
            assign out_idxs[g*IDX_W +: IDX_W] = res[g].idx;
        end
    endgenerate

    assign plan = stage_plan(stg);

    tks_layer u_layer (
        .d    (work),
        .plan (plan),
        .q    (lay_q)
    );

    tks_pick u_pick (
        .w       (work),
        .taken_a (taken_a),
        .taken_b (taken_b),
        .best    (best),
        .from_a  (from_a)
    );

    assign in_ready  = (phase == PH_IDLE);
    assign out_valid = (phase == PH_HOLD);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            work    <= '0;
            res     <= '0;
            stg     <= '0;
            mode_q  <= 1'b0;
            k_q     <= K_W'(1);
            n_out   <= '0;
            taken_a <= '0;
            taken_b <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (in_valid) begin
                        work   <= in_items;
                        mode_q <= in_mode;
                        k_q    <= clamp_k(in_k);
                        stg    <= '0;
                        phase  <= PH_MERGE;
                    end
                end
                PH_MERGE: begin
                    work <= lay_q;
                    stg  <= stg + STG_W'(1);
                    if (!mode_q && stg == LAST_FULL) begin
                        res    <= lay_q;
                        done_q <= 1'b1;
                        phase  <= PH_HOLD;
                    end else if (mode_q && stg == LAST_MERGE) begin
                        res     <= '0;
                        n_out   <= '0;
                        taken_a <= '0;
                        taken_b <= '0;
                        phase   <= PH_PICK;
                    end
                end
                PH_PICK: begin
                    res[n_out] <= best;
                    if (from_a)
                        taken_a <= taken_a + CNT_W'(1);
                    else
                        taken_b <= taken_b + CNT_W'(1);
                    n_out <= n_out + K_W'(1);
                    if (n_out == k_q - K_W'(1)) begin
                        done_q <= 1'b1;
                        phase  <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (out_ack)
                        phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tks_check.sv
`timescale 1ns/1ps
module tks_check
    import tks_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_mode,
    input logic [K_W-1:0]     in_k,
    input logic               out_valid,
    input logic               out_ack,
    input logic               done,
    input logic [N*KEY_W-1:0] out_keys,
    input logic [N*IDX_W-1:0] out_idxs
);

    logic             mode_q;
    logic [K_W-1:0]   k_q;
    logic [LAT_W-1:0] lat_cnt;
    logic [LAT_W-1:0] lat_exp;
    logic             ordered;
    logic             tail_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            k_q     <= K_W'(1);
            lat_cnt <= '0;
            lat_exp <= '0;
        end else if (in_valid && in_ready) begin
            mode_q  <= in_mode;
            k_q     <= clamp_k(in_k);
            lat_cnt <= '0;
            lat_exp <= in_mode ? LAT_W'(MERGE_STG) + LAT_W'(clamp_k(in_k)) : LAT_W'(FULL_STG);
        end else if (!in_ready && !out_valid) begin
            lat_cnt <= lat_cnt + LAT_W'(1);
        end
    end

    always_comb begin
        item_t a;
        item_t b;
        ordered   = 1'b1;
        tail_zero = 1'b1;
        for (int i = 0; i < N - 1; i++) begin
            a = {out_keys[i*KEY_W +: KEY_W], out_idxs[i*IDX_W +: IDX_W]};
            b = {out_keys[(i+1)*KEY_W +: KEY_W], out_idxs[(i+1)*IDX_W +: IDX_W]};
            if (ranks_above(b, a))
                ordered = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            if (K_W'(i) >= k_q && (out_keys[i*KEY_W +: KEY_W] != '0 || out_idxs[i*IDX_W +: IDX_W] != '0))
                tail_zero = 1'b0;
        end
    end

    a_r1_full_ordered: assert property (@(posedge clk) disable iff (rst)
        out_valid && !mode_q |-> ordered);

    a_r4_tail_cleared: assert property (@(posedge clk) disable iff (rst)
        out_valid && mode_q |-> tail_zero);

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> lat_cnt == lat_exp);

    a_r7_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ack |=> out_valid && $stable(out_keys) && $stable(out_idxs));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ack |=> in_ready);

    a_r9_done_with_valid: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind topk_bitonic_sorter tks_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .in_k      (in_k),
    .out_valid (out_valid),
    .out_ack   (out_ack),
    .done      (done),
    .out_keys  (out_keys),
    .out_idxs  (out_idxs)
);

// File: tb/topk_bitonic_sorter_test.sv
`timescale 1ns/1ps
module topk_bitonic_sorter_test;
    import tks_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic               in_mode = 1'b0;
    logic [K_W-1:0]     in_k = '0;
    logic [N*KEY_W-1:0] in_keys = '0;
    logic [N*IDX_W-1:0] in_idxs = '0;
    logic               out_valid;
    logic               out_ack = 1'b0;
    logic               done;
    logic [N*KEY_W-1:0] out_keys;
    logic [N*IDX_W-1:0] out_idxs;

    always #2.5 clk = ~clk;

    topk_bitonic_sorter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_k(in_k), .in_keys(in_keys), .in_idxs(in_idxs),
        .out_valid(out_valid), .out_ack(out_ack), .done(done),
        .out_keys(out_keys), .out_idxs(out_idxs)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int tk[N];
    int ti[N];
    int ek[N];
    int ei[N];

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int keff(input int k);
        if (k == 0) return 1;
        if (k > 16) return 16;
        return k;
    endfunction

    // Cycle model of the handshake flags
    int m_phase = 0;
    int m_cnt   = 0;
    int m_lat   = 0;
    bit m_done  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0;
            m_done  = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (in_valid) begin
                       m_phase = 1;
                       m_cnt   = 0;
                       m_lat   = in_mode ? 10 + keff(int'(in_k)) : 15;
                   end
                1: begin
                       m_cnt++;
                       if (m_cnt == m_lat) begin
                           m_phase = 2;
                           m_done  = 1;
                       end
                   end
                default: if (out_ack) m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R7 in_ready per cycle", int'(in_ready), int'(m_phase == 0));
            chk("R8 out_valid per cycle", int'(out_valid), int'(m_phase == 2));
            chk("R9 done per cycle", int'(done), int'(m_done));
        end
    end

    task automatic build_ref(input bit mode, input int k);
        int sk[N];
        int si[N];
        for (int i = 0; i < N; i++) begin
            sk[i] = tk[i];
            si[i] = ti[i];
        end
        for (int i = 0; i < N; i++) begin
            int best = i;
            for (int j = i + 1; j < N; j++) begin
                if (sk[j] * 64 + (63 - si[j]) > sk[best] * 64 + (63 - si[best]))
                    best = j;
            end
            ek[i] = sk[best];
            ei[i] = si[best];
            sk[best] = sk[i];
            si[best] = si[i];
        end
        if (mode) begin
            for (int i = keff(k); i < N; i++) begin
                ek[i] = 0;
                ei[i] = 0;
            end
        end
    endtask

    task automatic compare_out(input string req);
        for (int i = 0; i < N; i++) begin
            chk({req, " key"}, int'(out_keys[i*KEY_W +: KEY_W]), ek[i]);
            chk({req, " R3 tag"}, int'(out_idxs[i*IDX_W +: IDX_W]), ei[i]);
        end
    endtask

    task automatic run_job(input bit mode, input int k, input string req,
                           input bit disturb, input int hold);
        int cyc;
        build_ref(mode, k);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_k     = K_W'(k);
        for (int i = 0; i < N; i++) begin
            in_keys[i*KEY_W +: KEY_W] = KEY_W'(tk[i]);
            in_idxs[i*IDX_W +: IDX_W] = IDX_W'(ti[i]);
        end
        @(negedge clk);
        cyc = 0;
        if (disturb) begin
            in_keys = ~in_keys;
            in_idxs = ~in_idxs;
            in_mode = ~mode;
            in_k    = K_W'(9);
            @(negedge clk);
            cyc++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        while (!out_valid && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " R6 latency"}, cyc, mode ? 10 + keff(k) : 15);
        compare_out(req);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk("R8 still valid", int'(out_valid), 1);
            compare_out("R8 held result");
        end
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk("R8 ready after ack", int'(in_ready), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R10 in_ready", int'(in_ready), 1);
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 done", int'(done), 0);

        // R1: random keys, unique tags
        for (int i = 0; i < N; i++) begin
            tk[i] = int'($urandom_range(255, 0));
            ti[i] = (i * 13 + 5) % 64;
        end
        run_job(1'b0, 0, "R1 random full", 1'b0, 0);

        // R2: all keys equal, order falls back to tags
        for (int i = 0; i < N; i++) begin
            tk[i] = 85;
            ti[i] = (i * 7 + 3) % 32 + 32;
        end
        run_job(1'b0, 0, "R2 equal keys full", 1'b0, 0);

        // R1 + R8: ascending input, result held several cycles
        for (int i = 0; i < N; i++) begin
            tk[i] = i * 8;
            ti[i] = i;
        end
        run_job(1'b0, 0, "R1 ascending full", 1'b0, 5);

        // R4: Top-K edges on random data
        for (int i = 0; i < N; i++) begin
            tk[i] = int'($urandom_range(255, 0));
            ti[i] = 63 - i;
        end
        run_job(1'b1, 1, "R4 top1", 1'b0, 0);
        run_job(1'b1, 16, "R4 top16", 1'b0, 0);

        // R2 + R4: heavy duplicates
        for (int i = 0; i < N; i++) begin
            tk[i] = (i % 4) * 60;
            ti[i] = (i * 11) % 64;
        end
        run_job(1'b1, 5, "R2 R4 dup top5", 1'b0, 0);
        run_job(1'b0, 0, "R2 dup full", 1'b0, 0);

        // R5: K clamping
        run_job(1'b1, 0, "R5 k0", 1'b0, 0);
        run_job(1'b1, 25, "R5 k25", 1'b0, 0);

        // R7: input activity during a job is ignored
        for (int i = 0; i < N; i++) begin
            tk[i] = 255 - i * 3;
            ti[i] = i + 10;
        end
        run_job(1'b1, 3, "R7 disturbed top3", 1'b1, 0);
        run_job(1'b0, 0, "R7 disturbed full", 1'b1, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule